// File: doc/BRIEF.md
# Set-Associative Page Translation Buffer

This block keeps a small cache of recent virtual-to-physical page translations for 4 KB pages. A lookup presents a full virtual address. The low twelve bits pass straight through. The virtual page number above them is cut into a set index and a tag. Every way of the chosen set is compared with the tag at the same time, and the matching way's frame number, access-control field and dirty flag are selected. The result is registered, so the answer appears on the cycle after the request.

A miss tells the surrounding logic to walk the page tables. The walker then writes the translation back through the fill port. A fill goes to a free way of the set when one exists. Otherwise it replaces the way named by a round-robin pointer kept for that set. Two maintenance inputs remove entries. A snoop invalidate drops the single entry for a page that has been swapped out. A flush empties the whole buffer when the address space is switched.

Top module: `pxl_tlb`

## Requirements
- R1: On a hit, `lk_paddr[11:0]` equals `lk_vaddr[11:0]` of the request, and `lk_paddr[31:12]` is the frame number stored with the matching entry.
- R2: A lookup sampled at a clock edge makes exactly one of `lk_hit` and `lk_miss` high during the following cycle. Neither is high after a cycle with no request. A lookup sees the contents as they were before any fill, invalidate or flush applied at the same edge.
- R3: The set index is `lk_vaddr[15:12]` and the tag is `lk_vaddr[31:16]`. A lookup hits only when a valid entry of that set holds that tag, and the four ways of the set are all candidates.
- R4: On a hit, `lk_acc` (a 3-bit field returned exactly as it was filled) and `lk_dirty` carry the values written with the matching entry.
- R5: A flush invalidates every entry. Lookups miss after it until the page is filled again.
- R6: An invalidate removes only the entry holding `inv_vpn`, and the other entries of the set still hit. An invalidate of a page that is not held changes nothing.
- R7: A fill of a page that is not held, into a set with a free way, takes the lowest-numbered free way. No valid entry is lost.
- R8: A fill of a page that is not held, into a full set, replaces the way named by that set's pointer. Each pointer starts at way 0 after reset and steps by one (modulo 4) after each such replacement. Pointers of different sets are independent, and a flush leaves them unchanged.
- R9: A fill of a page already held rewrites that entry in place. Every other entry stays, and the pointer does not move.
- R10: A fill that coincides with an invalidate or a flush is discarded.
- R11: After reset the buffer is empty and `lk_hit` and `lk_miss` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Registered: previous request hit |
| lk_miss | output | 1 | Registered: previous request missed, page table walk needed |
| lk_paddr | output | 32 | Physical address of the last hit |
| lk_acc | output | 3 | Access-control field of the last hit |
| lk_dirty | output | 1 | Dirty flag of the last hit |
| fill_en | input | 1 | Write a translation after a table walk |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_pfn | input | 20 | Frame number of the fill |
| fill_acc | input | 3 | Access-control field of the fill |
| fill_dirty | input | 1 | Dirty flag of the fill |
| inv_en | input | 1 | Snoop invalidate of one page |
| inv_vpn | input | 20 | Page to invalidate |
| flush_en | input | 1 | Invalidate all entries |

## Verification
Lookups are tried against an empty buffer, against partly and fully occupied sets, and with tags that match in a wrong set or in a set that holds a wrong tag. Together these separate the set decode from the tag compare. Fill streams that overrun a set by several entries, in two sets at once, show whether replacement follows a separate pointer per set. A fill repeated for a page already held shows whether the block makes a duplicate. Same-cycle combinations of lookup with fill or invalidate, and of fill with invalidate or flush, show the read-before-write order and the priority of maintenance. A long mixed stream then runs on a small pool of pages so that hits, conflicts, invalidates and occasional flushes interleave.

// File: rtl/pxl_tlb_pkg.sv
package pxl_tlb_pkg;
  localparam int unsigned PAGE_W = 12;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned PA_W   = 32;
  localparam int unsigned ACC_W  = 3;
  localparam int unsigned VPN_W  = VA_W - PAGE_W;
  localparam int unsigned PFN_W  = PA_W - PAGE_W;

  // translation payload held with every entry
  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [ACC_W-1:0] acc;
    logic             dirty;
  } xlat_t;
endpackage

// File: rtl/pxl_tlb_rst_sync.sv
module pxl_tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/pxl_tlb_store.sv
module pxl_tlb_store
  import pxl_tlb_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             a_set,
  output logic [WAYS-1:0]              a_valid,
  output logic [WAYS-1:0][TAG_W-1:0]   a_tag,
  output xlat_t [WAYS-1:0]             a_data,
  input  logic [IDX_W-1:0]             b_set,
  output logic [WAYS-1:0]              b_valid,
  output logic [WAYS-1:0][TAG_W-1:0]   b_tag,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_set,
  input  logic [WAYS-1:0]              wr_way,
  input  logic [TAG_W-1:0]             wr_tag,
  input  xlat_t                        wr_data,
  input  logic                         clr_en,
  input  logic [IDX_W-1:0]             clr_set,
  input  logic [WAYS-1:0]              clr_way,
  input  logic                         flush_en
);
  logic [SETS-1:0][WAYS-1:0] vld_q, vld_d;
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  xlat_t [WAYS-1:0]           dat_q [SETS];

  // valid bits: flush beats invalidate beats fill
  always_comb begin
    vld_d = vld_q;
    if (flush_en) begin
      vld_d = '0;
    end else begin
      if (clr_en) vld_d[clr_set] = vld_q[clr_set] & ~clr_way;
      if (wr_en)  vld_d[wr_set]  = vld_q[wr_set] | wr_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // payload: enabled write, no reset
  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (wr_en && (wr_set == IDX_W'(s)) && wr_way[w]) begin
          tag_q[s][w] <= wr_tag;
          dat_q[s][w] <= wr_data;
        end
      end
    end
  end

  assign a_valid = vld_q[a_set];
  assign a_tag   = tag_q[a_set];
  assign a_data  = dat_q[a_set];
  assign b_valid = vld_q[b_set];
  assign b_tag   = tag_q[b_set];

  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> (vld_q == '0));
  p_wr_way_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot(wr_way));
  p_wr_clr_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr_en));
endmodule

// File: rtl/pxl_tlb_cmp.sv
module pxl_tlb_cmp #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit
);
  // one comparator per way, all in parallel
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = valid[w] && (tags[w] == key);
  end
  assign hit = |hit_vec;
endmodule

// File: rtl/pxl_tlb_victim.sv
module pxl_tlb_victim #(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 4,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned WIDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set,
  input  logic [WAYS-1:0]  set_valid,
  input  logic [WAYS-1:0]  set_hit,
  input  logic             alloc_en,
  output logic [WAYS-1:0]  way
);
  logic [SETS-1:0][WIDX_W-1:0] ptr_q, ptr_d;
  logic [WAYS-1:0]             free_way;
  logic                        full;
  logic                        evict;

  assign full  = &set_valid;
  assign evict = alloc_en && full && !(|set_hit);

  // lowest-numbered free way
  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) begin
        free_way    = '0;
        free_way[w] = 1'b1;
      end
    end
  end

  // existing entry, else free way, else pointer
  always_comb begin
    way = '0;
    if (|set_hit)   way = set_hit;
    else if (!full) way = free_way;
    else            way[ptr_q[set]] = 1'b1;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (evict) begin
      ptr_d[set] = (ptr_q[set] == WIDX_W'(WAYS - 1)) ? '0 : ptr_q[set] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  p_victim_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> $onehot(way));
  p_ptr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_en |=> $stable(ptr_q));
  p_free_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !full && !(|set_hit)) |-> ((way & set_valid) == '0));
endmodule

// File: rtl/pxl_tlb.sv
module pxl_tlb
  import pxl_tlb_pkg::*;
#(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  output logic [ACC_W-1:0] lk_acc,
  output logic             lk_dirty,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [ACC_W-1:0] fill_acc,
  input  logic             fill_dirty,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             flush_en
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = VPN_W - IDX_W;

  logic rst_sn;

  pxl_tlb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  // lookup address split
  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  assign lk_vpn = lk_vaddr[VA_W-1:PAGE_W];
  assign lk_set = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];

  // maintenance address: invalidate owns the port when present
  logic [VPN_W-1:0] mt_vpn;
  logic [IDX_W-1:0] mt_set;
  logic [TAG_W-1:0] mt_tag;
  assign mt_vpn = inv_en ? inv_vpn : fill_vpn;
  assign mt_set = mt_vpn[IDX_W-1:0];
  assign mt_tag = mt_vpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0]            a_valid, b_valid;
  logic [WAYS-1:0][TAG_W-1:0] a_tag, b_tag;
  xlat_t [WAYS-1:0]           a_data;
  logic [WAYS-1:0]            a_hit_vec, mt_hit_vec;
  logic                       a_hit, mt_hit;
  logic [WAYS-1:0]            fill_way;
  logic                       fill_go, clr_go;
  xlat_t                      fill_data;

  assign fill_go   = fill_en && !inv_en && !flush_en;
  assign clr_go    = inv_en && !flush_en && mt_hit;
  assign fill_data = '{pfn: fill_pfn, acc: fill_acc, dirty: fill_dirty};

  pxl_tlb_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_sn),
    .a_set(lk_set), .a_valid(a_valid), .a_tag(a_tag), .a_data(a_data),
    .b_set(mt_set), .b_valid(b_valid), .b_tag(b_tag),
    .wr_en(fill_go), .wr_set(mt_set), .wr_way(fill_way), .wr_tag(mt_tag),
    .wr_data(fill_data),
    .clr_en(clr_go), .clr_set(mt_set), .clr_way(mt_hit_vec),
    .flush_en(flush_en)
  );

  pxl_tlb_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp_lk (
    .valid(a_valid), .tags(a_tag), .key(lk_tag),
    .hit_vec(a_hit_vec), .hit(a_hit)
  );

  pxl_tlb_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp_mt (
    .valid(b_valid), .tags(b_tag), .key(mt_tag),
    .hit_vec(mt_hit_vec), .hit(mt_hit)
  );

  pxl_tlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_sn),
    .set(mt_set), .set_valid(b_valid), .set_hit(mt_hit_vec),
    .alloc_en(fill_go), .way(fill_way)
  );

  // way multiplexer (and-or, hit vector is one-hot or empty)
  xlat_t a_sel;
  always_comb begin
    a_sel = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (a_hit_vec[w]) a_sel = xlat_t'(a_sel | a_data[w]);
    end
  end

  // response stage
  logic             hit_d, miss_d, res_ld;
  logic [PA_W-1:0]  pa_d;
  logic             hit_q, miss_q, dirty_q;
  logic [PA_W-1:0]  pa_q;
  logic [ACC_W-1:0] acc_q;

  assign hit_d  = lk_req && a_hit;
  assign miss_d = lk_req && !a_hit;
  assign res_ld = hit_d;
  assign pa_d   = {a_sel.pfn, lk_vaddr[PAGE_W-1:0]};

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
      pa_q    <= '0;
      acc_q   <= '0;
      dirty_q <= 1'b0;
    end else begin
      hit_q  <= hit_d;
      miss_q <= miss_d;
      if (res_ld) begin
        pa_q    <= pa_d;
        acc_q   <= a_sel.acc;
        dirty_q <= a_sel.dirty;
      end
    end
  end

  assign lk_hit   = hit_q;
  assign lk_miss  = miss_q;
  assign lk_paddr = pa_q;
  assign lk_acc   = acc_q;
  assign lk_dirty = dirty_q;

  p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    lk_req |=> (lk_hit != lk_miss));
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !lk_req |=> (!lk_hit && !lk_miss));
  p_offset_copy_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (lk_req && a_hit) |=> (lk_paddr[PAGE_W-1:0] == $past(lk_vaddr[PAGE_W-1:0])));
  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(a_hit_vec) && $onehot0(mt_hit_vec));
  p_flush_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    flush_en ##1 lk_req |=> !lk_hit);
endmodule

// File: tb/pxl_tlb_bench.sv
module pxl_tlb_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_vaddr;
  logic        lk_hit, lk_miss, lk_dirty;
  logic [31:0] lk_paddr;
  logic [2:0]  lk_acc;
  logic        fill_en, fill_dirty, inv_en, flush_en;
  logic [19:0] fill_vpn, fill_pfn, inv_vpn;
  logic [2:0]  fill_acc;

  always #2 clk = ~clk;

  pxl_tlb u_pxl_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .lk_acc(lk_acc), .lk_dirty(lk_dirty),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_acc(fill_acc), .fill_dirty(fill_dirty),
    .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_en(flush_en)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R11";
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s got %0h exp %0h", cur_req, what, got, exp);
    end
  endtask

  // behavioural model: per set a list of held pages with their way slot
  bit          m_v   [16][4];
  int          m_vpn [16][4];
  int          m_pfn [16][4];
  int          m_acc [16][4];
  int          m_d   [16][4];
  int          m_ptr [16];
  bit          e_hit, e_miss, e_d;
  logic [31:0] e_pa;
  logic [2:0]  e_acc;

  function automatic int find(input int s, input int vpn);
    for (int w = 0; w < 4; w++) if (m_v[s][w] && m_vpn[s][w] == vpn) return w;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 16; s++) begin
        m_ptr[s] = 0;
        for (int w = 0; w < 4; w++) m_v[s][w] = 1'b0;
      end
      e_hit = 0; e_miss = 0;
    end else begin
      e_hit = 0; e_miss = 0;
      if (lk_req) begin
        int s, w;
        s = int'(lk_vaddr[15:12]);
        w = find(s, int'(lk_vaddr[31:12]));
        if (w >= 0) begin
          e_hit = 1;
          e_pa  = {m_pfn[s][w][19:0], lk_vaddr[11:0]};
          e_acc = m_acc[s][w][2:0];
          e_d   = m_d[s][w][0];
        end else e_miss = 1;
      end
      if (flush_en) begin
        for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) m_v[s][w] = 1'b0;
      end else if (inv_en) begin
        int s, w;
        s = int'(inv_vpn[3:0]);
        w = find(s, int'(inv_vpn));
        if (w >= 0) m_v[s][w] = 1'b0;
      end else if (fill_en) begin
        int s, w;
        s = int'(fill_vpn[3:0]);
        w = find(s, int'(fill_vpn));
        if (w < 0) begin
          for (int k = 3; k >= 0; k--) if (!m_v[s][k]) w = k;
        end
        if (w < 0) begin
          w = m_ptr[s];
          m_ptr[s] = (m_ptr[s] + 1) % 4;
        end
        m_v[s][w] = 1'b1; m_vpn[s][w] = int'(fill_vpn); m_pfn[s][w] = int'(fill_pfn);
        m_acc[s][w] = int'(fill_acc); m_d[s][w] = int'(fill_dirty);
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(lk_hit == e_hit, "lk_hit", 32'(lk_hit), 32'(e_hit));
      chk(lk_miss == e_miss, "lk_miss", 32'(lk_miss), 32'(e_miss));
      if (e_hit) begin
        chk(lk_paddr == e_pa, "lk_paddr", lk_paddr, e_pa);
        chk(lk_acc == e_acc, "lk_acc", 32'(lk_acc), 32'(e_acc));
        chk(lk_dirty == e_d, "lk_dirty", 32'(lk_dirty), 32'(e_d));
      end
    end
  end

  function automatic logic [19:0] pg(input int tag, input int set);
    return {tag[15:0], set[3:0]};
  endfunction

  task automatic drive(input bit lk, input logic [31:0] va, input bit fe, input logic [19:0] fv,
                       input logic [19:0] fp, input logic [2:0] fa, input bit fd,
                       input bit ie, input logic [19:0] iv, input bit fl);
    lk_req = lk; lk_vaddr = va; fill_en = fe; fill_vpn = fv; fill_pfn = fp;
    fill_acc = fa; fill_dirty = fd; inv_en = ie; inv_vpn = iv; flush_en = fl;
    @(negedge clk);
    lk_req = 0; fill_en = 0; inv_en = 0; flush_en = 0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off);
    drive(1, {vpn, off}, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] acc, input bit d);
    drive(0, 0, 1, vpn, pfn, acc, d, 0, 0, 0);
  endtask
  task automatic inval(input logic [19:0] vpn);
    drive(0, 0, 0, 0, 0, 0, 0, 1, vpn, 0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_err++; n_chk++;
      $display("FAIL R2 watchdog expired got 0 exp 1");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; lk_req = 0; lk_vaddr = 0; fill_en = 0; fill_vpn = 0; fill_pfn = 0;
    fill_acc = 0; fill_dirty = 0; inv_en = 0; inv_vpn = 0; flush_en = 0;
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    cur_req = "R11";
    chk(lk_hit == 0, "lk_hit in reset", 32'(lk_hit), 0);
    chk(lk_miss == 0, "lk_miss in reset", 32'(lk_miss), 0);
    rst_n = 1;
    idle(4);
    look(pg(1, 5), 12'h010); look(pg(0, 0), 12'h000); look(pg(16'hFFFF, 15), 12'hFFF);

    // R7: free ways filled in order
    cur_req = "R7";
    fill(pg(1, 5), 20'h11111, 3'd1, 0);
    fill(pg(2, 5), 20'h22222, 3'd2, 1);
    fill(pg(3, 5), 20'h33333, 3'd3, 0);
    look(pg(1, 5), 12'h000); look(pg(2, 5), 12'h000); look(pg(3, 5), 12'h000);

    // R3: set and tag decode
    cur_req = "R3";
    look(pg(2, 5), 12'h123);
    look(pg(2, 6), 12'h123);
    look(pg(9, 5), 12'h123);
    look(pg(16'h0002 | 16'h8000, 5), 12'h000);

    // R1: offset pass-through at the extremes
    cur_req = "R1";
    look(pg(1, 5), 12'h000); look(pg(1, 5), 12'hFFF); look(pg(3, 5), 12'hA5A);

    // R4: access field and dirty flag
    cur_req = "R4";
    fill(pg(7, 6), 20'hABCDE, 3'd5, 1);
    fill(pg(8, 6), 20'h0F0F0, 3'd2, 0);
    look(pg(7, 6), 12'h004); look(pg(8, 6), 12'h008);

    // R8: overrun sets 5 and 9, pointers independent
    cur_req = "R8";
    fill(pg(4, 5), 20'h44444, 3'd4, 0);
    for (int t = 10; t < 15; t++) fill(pg(t, 5), 20'(t * 4097), 3'(t), t[0]);
    for (int t = 20; t < 26; t++) fill(pg(t, 9), 20'(t * 333), 3'(t), t[1]);
    for (int t = 1; t < 15; t++) look(pg(t, 5), 12'(t));
    for (int t = 20; t < 26; t++) look(pg(t, 9), 12'(t));

    // R9: refill of a held page
    cur_req = "R9";
    fill(pg(14, 5), 20'hEEEEE, 3'd7, 1);
    fill(pg(15, 5), 20'h15151, 3'd1, 0);
    for (int t = 10; t < 16; t++) look(pg(t, 5), 12'h0FF);

    // R6: single-page invalidate
    cur_req = "R6";
    inval(pg(13, 5));
    look(pg(13, 5), 12'h0); look(pg(12, 5), 12'h0); look(pg(14, 5), 12'h0);
    inval(pg(99, 5));
    inval(pg(99, 3));
    for (int t = 10; t < 16; t++) look(pg(t, 5), 12'h1);
    cur_req = "R7";
    fill(pg(40, 5), 20'h40404, 3'd0, 1);
    for (int t = 10; t < 16; t++) look(pg(t, 5), 12'h2);
    look(pg(40, 5), 12'h3);

    // R10: fill dropped against invalidate or flush
    cur_req = "R10";
    drive(0, 0, 1, pg(30, 7), 20'h30303, 3'd3, 1, 1, pg(7, 6), 0);
    look(pg(30, 7), 12'h0); look(pg(7, 6), 12'h0); look(pg(8, 6), 12'h0);
    drive(0, 0, 1, pg(31, 7), 20'h31313, 3'd3, 0, 0, 0, 1);
    look(pg(31, 7), 12'h0); look(pg(8, 6), 12'h0); look(pg(40, 5), 12'h0);

    // R5: flush empties; R8 pointer survives flush
    cur_req = "R5";
    fill(pg(50, 2), 20'h50505, 3'd1, 0);
    fill(pg(51, 3), 20'h51515, 3'd2, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    look(pg(50, 2), 12'h0); look(pg(51, 3), 12'h0);
    cur_req = "R8";
    for (int t = 60; t < 66; t++) fill(pg(t, 5), 20'(t * 77), 3'(t), 0);
    for (int t = 60; t < 66; t++) look(pg(t, 5), 12'(t));

    // R2: same-edge lookup sees old contents
    cur_req = "R2";
    drive(1, {pg(70, 11), 12'h111}, 1, pg(70, 11), 20'h70707, 3'd6, 1, 0, 0, 0);
    look(pg(70, 11), 12'h222);
    drive(1, {pg(70, 11), 12'h333}, 0, 0, 0, 0, 0, 1, pg(70, 11), 0);
    look(pg(70, 11), 12'h444);
    idle(2);

    // R3: mixed stream on a small page pool
    cur_req = "R3";
    begin
      int unsigned r;
      r = 32'h1234_5678;
      for (int i = 0; i < 2000; i++) begin
        logic [19:0] v;
        int op;
        r = r * 1103515245 + 12345;
        v = pg(int'((r >> 4) % 6), int'((r >> 9) % 3));
        op = int'((r >> 14) % 8);
        if (((r >> 20) % 64) == 0) drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        else if (op < 4) look(v, 12'(r >> 3));
        else if (op < 6) fill(v, 20'(r >> 7), 3'(r >> 2), r[12]);
        else if (op == 6) inval(v);
        else drive(1, {v, 12'(r)}, 1, pg(int'((r >> 23) % 6), int'((r >> 9) % 3)),
                   20'(r >> 5), 3'(r >> 1), r[17], 0, 0, 0);
      end
    end
    idle(3);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule